// File: doc/BRIEF.md
# Store Queue with Load Forwarding

This block is a small circular store queue with a query port for a load pipeline. Stores take an entry at the tail and later receive their address (a virtual line, a physical line and a 16-byte byte mask) and their data in separate writes. Each entry carries an address-known flag and a data-known flag. Entries leave from the head in allocation order.

A load presents its virtual line, its physical line, its byte mask and a one-hot-per-entry vector naming the entries that are older than it. The load stage computes that vector earlier, so the block never compares queue pointers on the query path. One cycle after the query, the block returns a fast per-byte forward mask and a fast data-missing flag. One cycle after that, it returns the final forward mask and the forwarded bytes. It also returns three status flags: data not ready, address not ready and alias mismatch. The first two each carry the index of the entry that caused them. The load pipeline uses these flags to decide whether to replay the load or to flush.

Top module: `sqf_top`

## Requirements
- R1: An allocation request takes the entry at `alloc_idx` and clears that entry's address-known and data-known flags. After NENT allocations with no frees, `sq_full` is 1. An allocation request made while the queue is full changes nothing.
- R2: A free request releases the oldest entry. `sq_empty` is 1 when no entry is held. A free request made while the queue is empty changes nothing.
- R3: An address write takes effect in two steps. A query presented one cycle after the write request still sees the entry's address as unknown. A query presented two cycles after the request sees the written address.
- R4: A data write marks the entry's data as known. A query presented in the cycle after the write sees the new data.
- R5: An entry matches a load when four conditions hold: its bit in `ld_older` is 1, its address is known, its physical line equals `ld_pline`, and its byte mask overlaps `ld_mask`. Only matching entries can supply bytes.
- R6: For each byte that the load wants, the candidate writer is the youngest matching entry whose mask covers that byte. Age follows the circular allocation order, starting at the head, and this order holds across pointer wrap.
- R7: One cycle after `ld_valid`, `fast_valid` is 1. `fast_fwd_mask` is the OR of the masks of the matching entries whose data is known, ANDed with `ld_mask`. `fast_data_inv` is 1 when any matching entry lacks data.
- R8: Two cycles after `ld_valid`, `res_valid` is 1. A bit of `res_fwd_mask` is 1 when that byte's candidate writer has known data. Byte b of `res_data` sits at bits 8b+7..8b and holds that writer's byte. Bytes that are not forwarded read 0.
- R9: `res_data_inv` is 1 when the candidate writer of some byte has no data. `res_data_inv_idx` gives the youngest such writer.
- R10: An older entry with an unknown address sets `res_addr_inv`, and `res_addr_inv_idx` gives the youngest such entry. Entries with an unknown address never forward.
- R11: `res_match_inv` is 1 when the set of entries matched by virtual line differs from the set matched by physical line. The virtual set uses the same rule as R5 but compares `ld_vline`.
- R12: An entry whose `ld_older` bit is 0 has no effect on any query output, even if its address matches.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| alloc_valid | input | 1 | Allocate the entry at the tail |
| alloc_idx | output | $clog2(NENT) | Index the next allocation takes |
| sq_full | output | 1 | All entries held |
| sq_empty | output | 1 | No entry held |
| free_valid | input | 1 | Release the head entry |
| aw_valid | input | 1 | Address write request |
| aw_idx | input | $clog2(NENT) | Entry written by the address write |
| aw_vline | input | VLW | Virtual address bits above the 16-byte offset |
| aw_pline | input | PLW | Physical address bits above the 16-byte offset |
| aw_mask | input | 16 | Store byte mask |
| dw_valid | input | 1 | Data write request |
| dw_idx | input | $clog2(NENT) | Entry written by the data write |
| dw_data | input | 128 | Store data, byte b at bits 8b+7..8b |
| ld_valid | input | 1 | Load query request |
| ld_vline | input | VLW | Load virtual line |
| ld_pline | input | PLW | Load physical line |
| ld_mask | input | 16 | Load byte mask |
| ld_older | input | NENT | One bit per entry: entry is older than the load |
| fast_valid | output | 1 | Fast result valid |
| fast_fwd_mask | output | 16 | Fast forward mask |
| fast_data_inv | output | 1 | Fast data-missing flag |
| res_valid | output | 1 | Final result valid |
| res_fwd_mask | output | 16 | Final forward mask |
| res_data | output | 128 | Forwarded bytes |
| res_data_inv | output | 1 | Some candidate writer has no data |
| res_data_inv_idx | output | $clog2(NENT) | Youngest writer without data |
| res_addr_inv | output | 1 | Older entry with unknown address |
| res_addr_inv_idx | output | $clog2(NENT) | Youngest such entry |
| res_match_inv | output | 1 | Virtual and physical match sets differ |

## Verification
The block assumes that nothing writes an entry, and no pointer moves, while a query is between its request and its final result. It also assumes that `ld_older` names only held entries and that no address or data write targets an entry in the same cycle that it is allocated. The bench meets these assumptions by running each query to completion on an otherwise idle queue. It issues writes only to allocated entries. The single exception is the directed R3 case, which deliberately overlaps a query with a pending address write.

// File: rtl/sqf_pkg.sv
package sqf_pkg;
  localparam int LINE_BYTES = 16;
  typedef logic [LINE_BYTES-1:0]   bmask_t;
  typedef logic [8*LINE_BYTES-1:0] line_t;
endpackage

// File: rtl/sqf_ptrs.sv
// Circular head/tail pointers with wrap bits (R1, R2).
module sqf_ptrs #(
  parameter int NENT = 8,
  localparam int IW = $clog2(NENT)
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          alloc_req,
  input  logic          free_req,
  output logic [IW-1:0] head_idx,
  output logic [IW-1:0] tail_idx,
  output logic          full,
  output logic          empty,
  output logic          alloc_fire
);
  logic [IW:0] head_q, tail_q;
  logic        free_fire;

  assign full       = (head_q[IW] != tail_q[IW]) && (head_q[IW-1:0] == tail_q[IW-1:0]);
  assign empty      = (head_q == tail_q);
  assign alloc_fire = alloc_req && !full;
  assign free_fire  = free_req && !empty;
  assign head_idx   = head_q[IW-1:0];
  assign tail_idx   = tail_q[IW-1:0];

  always_ff @(posedge clk) begin
    if (rst) begin
      head_q <= '0;
      tail_q <= '0;
    end else begin
      if (alloc_fire) tail_q <= tail_q + 1'b1;
      if (free_fire)  head_q <= head_q + 1'b1;
    end
  end
endmodule

// File: rtl/sqf_store.sv
// Entry storage: address writes pass a staging register (R3), data writes land directly (R4).
module sqf_store
  import sqf_pkg::*;
#(
  parameter int NENT = 8,
  parameter int VLW  = 35,
  parameter int PLW  = 32,
  localparam int IW = $clog2(NENT)
) (
  input  logic           clk,
  input  logic           rst,
  input  logic           alloc_fire,
  input  logic [IW-1:0]  alloc_idx,
  input  logic           aw_valid,
  input  logic [IW-1:0]  aw_idx,
  input  logic [VLW-1:0] aw_vline,
  input  logic [PLW-1:0] aw_pline,
  input  bmask_t         aw_mask,
  input  logic           dw_valid,
  input  logic [IW-1:0]  dw_idx,
  input  line_t          dw_data,
  output logic [VLW-1:0] e_vline [NENT],
  output logic [PLW-1:0] e_pline [NENT],
  output bmask_t         e_mask  [NENT],
  output line_t          e_data  [NENT],
  output logic [NENT-1:0] e_av,
  output logic [NENT-1:0] e_dv
);
  logic           awq_v;
  logic [IW-1:0]  awq_idx;
  logic [VLW-1:0] awq_vline;
  logic [PLW-1:0] awq_pline;
  bmask_t         awq_mask;

  always_ff @(posedge clk) begin
    if (rst) awq_v <= 1'b0;
    else     awq_v <= aw_valid;
    awq_idx   <= aw_idx;
    awq_vline <= aw_vline;
    awq_pline <= aw_pline;
    awq_mask  <= aw_mask;
  end

  for (genvar g = 0; g < NENT; g++) begin : g_ent
    always_ff @(posedge clk) begin
      if (rst) begin
        e_av[g] <= 1'b0;
        e_dv[g] <= 1'b0;
      end else begin
        if (alloc_fire && alloc_idx == IW'(g)) begin
          e_av[g] <= 1'b0;
          e_dv[g] <= 1'b0;
        end
        if (awq_v && awq_idx == IW'(g)) e_av[g] <= 1'b1;
        if (dw_valid && dw_idx == IW'(g)) e_dv[g] <= 1'b1;
      end
    end

    always_ff @(posedge clk) begin
      if (awq_v && awq_idx == IW'(g)) begin
        e_vline[g] <= awq_vline;
        e_pline[g] <= awq_pline;
        e_mask[g]  <= awq_mask;
      end
      if (dw_valid && dw_idx == IW'(g)) e_data[g] <= dw_data;
    end
  end
endmodule

// File: rtl/sqf_match.sv
// First stage: match sets, per-byte youngest writer, flags (R5, R6, R7, R9, R10, R11, R12).
module sqf_match
  import sqf_pkg::*;
#(
  parameter int NENT = 8,
  parameter int VLW  = 35,
  parameter int PLW  = 32,
  localparam int IW = $clog2(NENT)
) (
  input  logic            clk,
  input  logic            rst,
  input  logic [VLW-1:0]  e_vline [NENT],
  input  logic [PLW-1:0]  e_pline [NENT],
  input  bmask_t          e_mask  [NENT],
  input  logic [NENT-1:0] e_av,
  input  logic [NENT-1:0] e_dv,
  input  logic [IW-1:0]   head_idx,
  input  logic            ld_valid,
  input  logic [VLW-1:0]  ld_vline,
  input  logic [PLW-1:0]  ld_pline,
  input  bmask_t          ld_mask,
  input  logic [NENT-1:0] ld_older,
  output logic            s1_valid,
  output bmask_t          s1_fast_mask,
  output logic            s1_fast_dinv,
  output bmask_t          s1_fwd,
  output logic [IW-1:0]   s1_sel [LINE_BYTES],
  output logic            s1_dinv,
  output logic [IW-1:0]   s1_dinv_idx,
  output logic            s1_ainv,
  output logic [IW-1:0]   s1_ainv_idx,
  output logic            s1_minv
);
  logic [NENT-1:0] pm, vm, unk;

  for (genvar g = 0; g < NENT; g++) begin : g_cmp
    logic known, ovl;
    assign known  = ld_older[g] && e_av[g];
    assign ovl    = |(e_mask[g] & ld_mask);
    assign pm[g]  = known && ovl && (e_pline[g] == ld_pline);
    assign vm[g]  = known && ovl && (e_vline[g] == ld_vline);
    assign unk[g] = ld_older[g] && !e_av[g];
  end

  function automatic logic [IW-1:0] ring(input logic [IW-1:0] h, input int k);
    return h + IW'(k);
  endfunction

  bmask_t          hit_c, selv_c, fm_c;
  logic [IW-1:0]   sel_c [LINE_BYTES];
  logic [NENT-1:0] nd_c;
  logic            dinv_c, ainv_c;
  logic [IW-1:0]   didx_c, aidx_c;

  always_comb begin
    hit_c  = '0;
    selv_c = '0;
    for (int b = 0; b < LINE_BYTES; b++) sel_c[b] = '0;
    // oldest to youngest: a later hit overrides, so the youngest writer wins
    for (int k = 0; k < NENT; k++) begin
      if (pm[ring(head_idx, k)]) begin
        for (int b = 0; b < LINE_BYTES; b++) begin
          if (e_mask[ring(head_idx, k)][b] && ld_mask[b]) begin
            hit_c[b]  = 1'b1;
            sel_c[b]  = ring(head_idx, k);
            selv_c[b] = e_dv[ring(head_idx, k)];
          end
        end
      end
    end
    nd_c = '0;
    for (int b = 0; b < LINE_BYTES; b++)
      if (hit_c[b] && !selv_c[b]) nd_c[sel_c[b]] = 1'b1;
    dinv_c = 1'b0;
    didx_c = '0;
    ainv_c = 1'b0;
    aidx_c = '0;
    for (int k = 0; k < NENT; k++) begin
      if (nd_c[ring(head_idx, k)]) begin
        dinv_c = 1'b1;
        didx_c = ring(head_idx, k);
      end
      if (unk[ring(head_idx, k)]) begin
        ainv_c = 1'b1;
        aidx_c = ring(head_idx, k);
      end
    end
    fm_c = '0;
    for (int g = 0; g < NENT; g++)
      if (pm[g] && e_dv[g]) fm_c = fm_c | e_mask[g];
    fm_c = fm_c & ld_mask;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      s1_valid     <= 1'b0;
      s1_fast_mask <= '0;
      s1_fast_dinv <= 1'b0;
      s1_fwd       <= '0;
      s1_dinv      <= 1'b0;
      s1_dinv_idx  <= '0;
      s1_ainv      <= 1'b0;
      s1_ainv_idx  <= '0;
      s1_minv      <= 1'b0;
    end else begin
      s1_valid     <= ld_valid;
      s1_fast_mask <= fm_c;
      s1_fast_dinv <= |(pm & ~e_dv);
      s1_fwd       <= hit_c & selv_c;
      s1_dinv      <= dinv_c;
      s1_dinv_idx  <= didx_c;
      s1_ainv      <= ainv_c;
      s1_ainv_idx  <= aidx_c;
      s1_minv      <= (vm != pm);
    end
  end

  always_ff @(posedge clk) begin
    for (int b = 0; b < LINE_BYTES; b++) s1_sel[b] <= sel_c[b];
  end
endmodule

// File: rtl/sqf_merge.sv
// Second stage: per-byte data gather and final registers (R8).
module sqf_merge
  import sqf_pkg::*;
#(
  parameter int NENT = 8,
  localparam int IW = $clog2(NENT)
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          s1_valid,
  input  bmask_t        s1_fwd,
  input  logic [IW-1:0] s1_sel [LINE_BYTES],
  input  logic          s1_dinv,
  input  logic [IW-1:0] s1_dinv_idx,
  input  logic          s1_ainv,
  input  logic [IW-1:0] s1_ainv_idx,
  input  logic          s1_minv,
  input  line_t         e_data [NENT],
  output logic          res_valid,
  output bmask_t        res_fwd_mask,
  output line_t         res_data,
  output logic          res_data_inv,
  output logic [IW-1:0] res_data_inv_idx,
  output logic          res_addr_inv,
  output logic [IW-1:0] res_addr_inv_idx,
  output logic          res_match_inv
);
  line_t lane_c;

  always_comb begin
    lane_c = '0;
    for (int b = 0; b < LINE_BYTES; b++)
      if (s1_fwd[b]) lane_c[8*b +: 8] = e_data[s1_sel[b]][8*b +: 8];
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      res_valid        <= 1'b0;
      res_fwd_mask     <= '0;
      res_data         <= '0;
      res_data_inv     <= 1'b0;
      res_data_inv_idx <= '0;
      res_addr_inv     <= 1'b0;
      res_addr_inv_idx <= '0;
      res_match_inv    <= 1'b0;
    end else begin
      res_valid        <= s1_valid;
      res_fwd_mask     <= s1_fwd;
      res_data         <= lane_c;
      res_data_inv     <= s1_dinv;
      res_data_inv_idx <= s1_dinv_idx;
      res_addr_inv     <= s1_ainv;
      res_addr_inv_idx <= s1_ainv_idx;
      res_match_inv    <= s1_minv;
    end
  end
endmodule

// File: rtl/sqf_top.sv
module sqf_top
  import sqf_pkg::*;
#(
  parameter int NENT = 8,
  parameter int VLW  = 35,
  parameter int PLW  = 32,
  localparam int IW = $clog2(NENT)
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            alloc_valid,
  output logic [IW-1:0]   alloc_idx,
  output logic            sq_full,
  output logic            sq_empty,
  input  logic            free_valid,
  input  logic            aw_valid,
  input  logic [IW-1:0]   aw_idx,
  input  logic [VLW-1:0]  aw_vline,
  input  logic [PLW-1:0]  aw_pline,
  input  logic [15:0]     aw_mask,
  input  logic            dw_valid,
  input  logic [IW-1:0]   dw_idx,
  input  logic [127:0]    dw_data,
  input  logic            ld_valid,
  input  logic [VLW-1:0]  ld_vline,
  input  logic [PLW-1:0]  ld_pline,
  input  logic [15:0]     ld_mask,
  input  logic [NENT-1:0] ld_older,
  output logic            fast_valid,
  output logic [15:0]     fast_fwd_mask,
  output logic            fast_data_inv,
  output logic            res_valid,
  output logic [15:0]     res_fwd_mask,
  output logic [127:0]    res_data,
  output logic            res_data_inv,
  output logic [IW-1:0]   res_data_inv_idx,
  output logic            res_addr_inv,
  output logic [IW-1:0]   res_addr_inv_idx,
  output logic            res_match_inv
);
  logic [IW-1:0]   head_idx;
  logic            alloc_fire;
  logic [VLW-1:0]  e_vline [NENT];
  logic [PLW-1:0]  e_pline [NENT];
  bmask_t          e_mask  [NENT];
  line_t           e_data  [NENT];
  logic [NENT-1:0] e_av, e_dv;
  bmask_t          s1_fwd;
  logic [IW-1:0]   s1_sel [LINE_BYTES];
  logic            s1_dinv, s1_ainv, s1_minv;
  logic [IW-1:0]   s1_dinv_idx, s1_ainv_idx;

  sqf_ptrs #(.NENT(NENT)) u_ptrs (
    .clk(clk), .rst(rst), .alloc_req(alloc_valid), .free_req(free_valid),
    .head_idx(head_idx), .tail_idx(alloc_idx), .full(sq_full), .empty(sq_empty),
    .alloc_fire(alloc_fire)
  );

  sqf_store #(.NENT(NENT), .VLW(VLW), .PLW(PLW)) u_store (
    .clk(clk), .rst(rst), .alloc_fire(alloc_fire), .alloc_idx(alloc_idx),
    .aw_valid(aw_valid), .aw_idx(aw_idx), .aw_vline(aw_vline), .aw_pline(aw_pline),
    .aw_mask(aw_mask), .dw_valid(dw_valid), .dw_idx(dw_idx), .dw_data(dw_data),
    .e_vline(e_vline), .e_pline(e_pline), .e_mask(e_mask), .e_data(e_data),
    .e_av(e_av), .e_dv(e_dv)
  );

  sqf_match #(.NENT(NENT), .VLW(VLW), .PLW(PLW)) u_match (
    .clk(clk), .rst(rst), .e_vline(e_vline), .e_pline(e_pline), .e_mask(e_mask),
    .e_av(e_av), .e_dv(e_dv), .head_idx(head_idx), .ld_valid(ld_valid),
    .ld_vline(ld_vline), .ld_pline(ld_pline), .ld_mask(ld_mask), .ld_older(ld_older),
    .s1_valid(fast_valid), .s1_fast_mask(fast_fwd_mask), .s1_fast_dinv(fast_data_inv),
    .s1_fwd(s1_fwd), .s1_sel(s1_sel), .s1_dinv(s1_dinv), .s1_dinv_idx(s1_dinv_idx),
    .s1_ainv(s1_ainv), .s1_ainv_idx(s1_ainv_idx), .s1_minv(s1_minv)
  );

  sqf_merge #(.NENT(NENT)) u_merge (
    .clk(clk), .rst(rst), .s1_valid(fast_valid), .s1_fwd(s1_fwd), .s1_sel(s1_sel),
    .s1_dinv(s1_dinv), .s1_dinv_idx(s1_dinv_idx), .s1_ainv(s1_ainv),
    .s1_ainv_idx(s1_ainv_idx), .s1_minv(s1_minv), .e_data(e_data),
    .res_valid(res_valid), .res_fwd_mask(res_fwd_mask), .res_data(res_data),
    .res_data_inv(res_data_inv), .res_data_inv_idx(res_data_inv_idx),
    .res_addr_inv(res_addr_inv), .res_addr_inv_idx(res_addr_inv_idx),
    .res_match_inv(res_match_inv)
  );
endmodule

// File: rtl/sqf_check.sv
module sqf_check #(
  parameter int NENT = 8,
  localparam int IW = $clog2(NENT)
) (
  input logic          clk,
  input logic          rst,
  input logic          alloc_valid,
  input logic          free_valid,
  input logic [IW-1:0] alloc_idx,
  input logic          sq_full,
  input logic          sq_empty,
  input logic          ld_valid,
  input logic [15:0]   ld_mask,
  input logic          fast_valid,
  input logic [15:0]   fast_fwd_mask,
  input logic          fast_data_inv,
  input logic          res_valid,
  input logic [15:0]   res_fwd_mask,
  input logic          res_data_inv
);
  a_r1_full_blocks_alloc: assert property (@(posedge clk) disable iff (rst)
    sq_full && alloc_valid && !free_valid |=> sq_full && $stable(alloc_idx));

  a_r1_full_not_empty: assert property (@(posedge clk) disable iff (rst)
    !(sq_full && sq_empty));

  a_r2_empty_blocks_free: assert property (@(posedge clk) disable iff (rst)
    sq_empty && free_valid && !alloc_valid |=> sq_empty);

  a_r7_fast_follows_query: assert property (@(posedge clk) disable iff (rst)
    ld_valid |=> fast_valid);

  a_r7_fast_within_load: assert property (@(posedge clk) disable iff (rst)
    fast_valid |-> (fast_fwd_mask & ~$past(ld_mask)) == 16'h0);

  a_r8_res_follows_fast: assert property (@(posedge clk) disable iff (rst)
    fast_valid |=> res_valid);

  a_r8_res_within_fast: assert property (@(posedge clk) disable iff (rst)
    res_valid |-> (res_fwd_mask & ~$past(fast_fwd_mask)) == 16'h0);

  a_r9_dinv_seen_fast: assert property (@(posedge clk) disable iff (rst)
    res_valid && res_data_inv |-> $past(fast_data_inv));
endmodule

bind sqf_top sqf_check #(.NENT(NENT)) u_chk (
  .clk(clk), .rst(rst), .alloc_valid(alloc_valid), .free_valid(free_valid),
  .alloc_idx(alloc_idx), .sq_full(sq_full), .sq_empty(sq_empty),
  .ld_valid(ld_valid), .ld_mask(ld_mask), .fast_valid(fast_valid),
  .fast_fwd_mask(fast_fwd_mask), .fast_data_inv(fast_data_inv),
  .res_valid(res_valid), .res_fwd_mask(res_fwd_mask), .res_data_inv(res_data_inv)
);

// File: tb/sim_sqf_top.sv
`timescale 1ns/1ps
module sim_sqf_top;
  localparam int N = 8, IW = 3, VLW = 35, PLW = 32;

  logic clk = 1'b0, rst = 1'b1;
  logic alloc_valid = 0, free_valid = 0, aw_valid = 0, dw_valid = 0, ld_valid = 0;
  logic [IW-1:0] aw_idx = '0, dw_idx = '0;
  logic [VLW-1:0] aw_vline = '0, ld_vline = '0;
  logic [PLW-1:0] aw_pline = '0, ld_pline = '0;
  logic [15:0] aw_mask = '0, ld_mask = '0;
  logic [127:0] dw_data = '0;
  logic [N-1:0] ld_older = '0;
  logic [IW-1:0] alloc_idx, res_data_inv_idx, res_addr_inv_idx;
  logic sq_full, sq_empty, fast_valid, fast_data_inv, res_valid;
  logic res_data_inv, res_addr_inv, res_match_inv;
  logic [15:0] fast_fwd_mask, res_fwd_mask;
  logic [127:0] res_data;

  sqf_top #(.NENT(N), .VLW(VLW), .PLW(PLW)) u0 (.*);

  always #5 clk = ~clk;

  int checks = 0, fails = 0;

  logic [VLW-1:0] m_v [N];
  logic [PLW-1:0] m_p [N];
  logic [15:0]    m_m [N];
  logic [127:0]   m_d [N];
  bit             m_av [N], m_dv [N];
  int             m_head, m_tail, m_cnt;

  task automatic chk(string req, logic [127:0] act, logic [127:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s act=%h exp=%h", req, act, exp);
    end
  endtask

  task automatic do_reset();
    rst = 1'b1;
    repeat (2) @(negedge clk);
    rst = 1'b0;
    m_head = 0; m_tail = 0; m_cnt = 0;
    for (int i = 0; i < N; i++) begin m_av[i] = 0; m_dv[i] = 0; end
  endtask

  task automatic do_alloc();
    alloc_valid = 1'b1;
    @(negedge clk);
    alloc_valid = 1'b0;
    if (m_cnt < N) begin
      m_av[m_tail] = 0; m_dv[m_tail] = 0;
      m_tail = (m_tail + 1) % N; m_cnt++;
    end
  endtask

  task automatic do_free();
    free_valid = 1'b1;
    @(negedge clk);
    free_valid = 1'b0;
    if (m_cnt > 0) begin m_head = (m_head + 1) % N; m_cnt--; end
  endtask

  task automatic do_aw(int idx, logic [VLW-1:0] v, logic [PLW-1:0] p, logic [15:0] m);
    aw_valid = 1'b1; aw_idx = IW'(idx); aw_vline = v; aw_pline = p; aw_mask = m;
    @(negedge clk);
    aw_valid = 1'b0;
    @(negedge clk);
    m_v[idx] = v; m_p[idx] = p; m_m[idx] = m; m_av[idx] = 1;
  endtask

  task automatic do_dw(int idx, logic [127:0] d);
    dw_valid = 1'b1; dw_idx = IW'(idx); dw_data = d;
    @(negedge clk);
    dw_valid = 1'b0;
    m_d[idx] = d; m_dv[idx] = 1;
  endtask

  // reference: scan from the youngest older store toward the oldest
  task automatic run_query(string tag, logic [VLW-1:0] v, logic [PLW-1:0] p,
                           logic [15:0] m, logic [N-1:0] older);
    bit pm [N], vm [N], got [16];
    int sel [16];
    logic [15:0] e_mask = 0, e_fast = 0;
    logic [127:0] e_data = 0;
    bit e_fdinv = 0, e_dinv = 0, e_ainv = 0, e_minv = 0;
    int e_didx = 0, e_aidx = 0;
    for (int i = 0; i < N; i++) begin
      pm[i] = older[i] && m_av[i] && ((m_m[i] & m) != 0) && (m_p[i] == p);
      vm[i] = older[i] && m_av[i] && ((m_m[i] & m) != 0) && (m_v[i] == v);
      if (pm[i] != vm[i]) e_minv = 1;
      if (pm[i] && m_dv[i]) e_fast = e_fast | (m_m[i] & m);
      if (pm[i] && !m_dv[i]) e_fdinv = 1;
    end
    for (int b = 0; b < 16; b++) begin got[b] = 0; sel[b] = 0; end
    for (int k = N - 1; k >= 0; k--) begin
      int ix = (m_head + k) % N;
      for (int b = 0; b < 16; b++)
        if (!got[b] && pm[ix] && m_m[ix][b] && m[b]) begin got[b] = 1; sel[b] = ix; end
    end
    for (int b = 0; b < 16; b++)
      if (got[b] && m_dv[sel[b]]) begin
        e_mask[b] = 1'b1;
        e_data[8*b +: 8] = m_d[sel[b]][8*b +: 8];
      end
    for (int k = N - 1; k >= 0; k--) begin
      int ix = (m_head + k) % N;
      bit nd = 0;
      for (int b = 0; b < 16; b++) if (got[b] && sel[b] == ix && !m_dv[ix]) nd = 1;
      if (nd && !e_dinv) begin e_dinv = 1; e_didx = ix; end
      if (older[ix] && !m_av[ix] && !e_ainv) begin e_ainv = 1; e_aidx = ix; end
    end
    ld_valid = 1'b1; ld_vline = v; ld_pline = p; ld_mask = m; ld_older = older;
    @(negedge clk);
    ld_valid = 1'b0;
    chk({tag, " R7 fast_valid"}, 128'(fast_valid), 128'(1));
    chk({tag, " R7 fast mask"}, 128'(fast_fwd_mask), 128'(e_fast));
    chk({tag, " R7 fast dinv"}, 128'(fast_data_inv), 128'(e_fdinv));
    @(negedge clk);
    chk({tag, " R8 res_valid"}, 128'(res_valid), 128'(1));
    chk({tag, " R8 fwd mask"}, 128'(res_fwd_mask), 128'(e_mask));
    chk({tag, " R8 data"}, res_data, e_data);
    chk({tag, " R9 dinv"}, 128'(res_data_inv), 128'(e_dinv));
    if (e_dinv) chk({tag, " R9 dinv idx"}, 128'(res_data_inv_idx), 128'(e_didx));
    chk({tag, " R10 ainv"}, 128'(res_addr_inv), 128'(e_ainv));
    if (e_ainv) chk({tag, " R10 ainv idx"}, 128'(res_addr_inv_idx), 128'(e_aidx));
    chk({tag, " R11 minv"}, 128'(res_match_inv), 128'(e_minv));
  endtask

  task automatic t_reset();
    do_reset();
    chk("R2 empty after reset", 128'(sq_empty), 128'(1));
    chk("R1 not full after reset", 128'(sq_full), 128'(0));
    chk("R1 alloc_idx after reset", 128'(alloc_idx), 128'(0));
    chk("R7 fast_valid after reset", 128'(fast_valid), 128'(0));
    chk("R8 res_valid after reset", 128'(res_valid), 128'(0));
  endtask

  task automatic t_ptrs();
    do_reset();
    for (int i = 0; i < N; i++) do_alloc();
    chk("R1 full after NENT allocs", 128'(sq_full), 128'(1));
    do_alloc();
    chk("R1 alloc while full: still full", 128'(sq_full), 128'(1));
    chk("R1 alloc while full: idx", 128'(alloc_idx), 128'(0));
    do_free();
    chk("R2 free clears full", 128'(sq_full), 128'(0));
    do_alloc();
    chk("R1 refill after wrap", 128'(sq_full), 128'(1));
    chk("R1 idx after wrap", 128'(alloc_idx), 128'(1));
    for (int i = 0; i < N; i++) do_free();
    chk("R2 empty after frees", 128'(sq_empty), 128'(1));
    do_free();
    chk("R2 free while empty ignored", 128'(sq_empty), 128'(1));
    do_alloc();
    chk("R1 alloc after empty", 128'(alloc_idx), 128'(2));
    do_free();
    chk("R2 head did not skip", 128'(sq_empty), 128'(1));
  endtask

  task automatic t_basic();
    do_reset();
    for (int i = 0; i < 4; i++) do_alloc();
    do_aw(0, 35'h100, 32'h900, 16'h00FF); do_dw(0, {16{8'hA0}});
    do_aw(1, 35'h100, 32'h900, 16'hFF00); do_dw(1, {16{8'hB1}});
    do_aw(2, 35'h200, 32'hA00, 16'hFFFF); do_dw(2, {16{8'hC2}});
    do_aw(3, 35'h100, 32'h900, 16'h000F); do_dw(3, {16{8'hD3}});
    run_query("R5 R6 all older", 35'h100, 32'h900, 16'hFFFF, 8'b0000_1111);
    run_query("R12 youngest excluded", 35'h100, 32'h900, 16'h00FF, 8'b0000_0111);
    run_query("R12 match but not older", 35'h200, 32'hA00, 16'hFFFF, 8'b0000_0011);
    run_query("R5 other line", 35'h300, 32'hB00, 16'hFFFF, 8'b0000_1111);
    run_query("R5 no mask overlap", 35'h100, 32'h900, 16'hFF00, 8'b0000_1001);
  endtask

  task automatic t_wrap();
    do_reset();
    for (int i = 0; i < 6; i++) begin do_alloc(); do_free(); end
    for (int i = 0; i < 4; i++) do_alloc();
    do_aw(6, 35'h40, 32'h40, 16'hFFFF); do_dw(6, {16{8'h66}});
    do_aw(7, 35'h40, 32'h40, 16'h00FF); do_dw(7, {16{8'h77}});
    do_aw(0, 35'h40, 32'h40, 16'h0F0F); do_dw(0, {16{8'h00}} | 128'h0102030405060708090A0B0C0D0E0F10);
    do_aw(1, 35'h40, 32'h40, 16'h0003); do_dw(1, {16{8'h11}});
    run_query("R6 wrap order", 35'h40, 32'h40, 16'hFFFF, 8'b1100_0011);
    run_query("R6 wrap minus youngest", 35'h40, 32'h40, 16'hFFFF, 8'b1100_0001);
  endtask

  task automatic t_dinv();
    do_reset();
    for (int i = 0; i < 3; i++) do_alloc();
    do_aw(0, 35'h7, 32'h7, 16'hFFFF); do_dw(0, {16{8'h5A}});
    do_aw(1, 35'h7, 32'h7, 16'h00FF);
    do_aw(2, 35'h7, 32'h7, 16'h000F);
    run_query("R9 two missing", 35'h7, 32'h7, 16'hFFFF, 8'b0000_0111);
    do_dw(2, {16{8'hE2}});
    run_query("R4 data next cycle", 35'h7, 32'h7, 16'hFFFF, 8'b0000_0111);
    do_dw(1, {16{8'hE1}});
    run_query("R4 all data", 35'h7, 32'h7, 16'hFFFF, 8'b0000_0111);
  endtask

  task automatic t_addr();
    do_reset();
    for (int i = 0; i < 3; i++) do_alloc();
    do_aw(0, 35'h9, 32'h9, 16'hFFFF); do_dw(0, {16{8'h3C}});
    run_query("R10 unknown addr", 35'h9, 32'h9, 16'hFFFF, 8'b0000_0011);
    aw_valid = 1'b1; aw_idx = 3'd1; aw_vline = 35'h9; aw_pline = 32'h9; aw_mask = 16'h00FF;
    @(negedge clk);
    aw_valid = 1'b0;
    run_query("R3 one cycle after write", 35'h9, 32'h9, 16'hFFFF, 8'b0000_0011);
    m_v[1] = 35'h9; m_p[1] = 32'h9; m_m[1] = 16'h00FF; m_av[1] = 1;
    run_query("R3 after two cycles", 35'h9, 32'h9, 16'hFFFF, 8'b0000_0011);
    run_query("R10 two unknown", 35'h9, 32'h9, 16'hFFFF, 8'b0000_0111);
  endtask

  task automatic t_minv();
    do_reset();
    for (int i = 0; i < 2; i++) do_alloc();
    do_aw(0, 35'h55, 32'h120, 16'hFFFF); do_dw(0, {16{8'h21}});
    do_aw(1, 35'h55, 32'h340, 16'h0FF0); do_dw(1, {16{8'h43}});
    run_query("R11 alias first", 35'h55, 32'h120, 16'hFFFF, 8'b0000_0011);
    run_query("R11 alias second", 35'h55, 32'h340, 16'hFFFF, 8'b0000_0011);
    run_query("R11 consistent", 35'h55, 32'h120, 16'hFFFF, 8'b0000_0001);
  endtask

  initial begin : wd
    repeat (100000) @(posedge clk);
    checks++; fails++;
    $display("FAIL watchdog expired");
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    t_reset();
    t_ptrs();
    t_basic();
    t_wrap();
    t_dinv();
    t_addr();
    t_minv();
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule